// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a small multicycle processor datapath that runs five instruction kinds: register-register arithmetic, OR with an immediate, word load, word store and branch-on-equal. It holds a 4-bit state register and drives the datapath's register enables, ALU operation select, memory strobes, register-file write controls and PC update controls on every cycle. The opcode of the latched instruction and the datapath's equality flag are its only data inputs.

Every instruction starts in a fetch state and moves on to a decode and operand-read state. Decode then dispatches on the opcode into a short path of execute, memory and write-back states, and the last state of each path returns to fetch. The paths differ in length, so branches take three cycles, loads five, and the other three kinds four. All controls are decoded from the state alone, except the PC source select in the branch state, which follows the equality flag captured during decode.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the sequencer leaves fetch only once the synchroniser has passed the release through.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, state_o is 0000 and the outputs show the fetch pattern (ir_en_o and mem_rd_o high, all other controls low, alu_op_o 00); after rst_ni rises, the state is first 0001 after the third rising clock edge (SYNC_STAGES = 2 edges of synchroniser plus one).
- R2: Fetch (0000) always moves to decode (0001) on the next edge; decode asserts exactly a_en_o, b_en_o and e_en_o.
- R3: From decode, opcode 000100 moves to 0011, 000000 to 0100, 001101 to 0110, 100011 to 1000 and 101011 to 1011.
- R4: Any other opcode in decode moves back to 0000, with no register-file write, memory write or PC update asserted on the way.
- R5: In 0011, pc_en_o is 1 and pc_sel_o equals eq_i (1 = branch target, 0 = PC + 4); pc_sel_o is 0 in every other state; 0011 moves to 0000.
- R6: Execute states assert s_en_o and drive alu_op_o: 10 (function code) in 0100, 01 (OR) in 0110, 00 (add) in 1000 and 1011; alu_op_o is 00 in all other states.
- R7: The paths run 0100→0101, 0110→0111, 1000→1001→1010 and 1011→1100; 0101 asserts reg_wr_o, reg_dst_o = 1 (rd) and pc_en_o; 0111 asserts reg_wr_o and pc_en_o with reg_dst_o = 0 (rt).
- R8: 1001 asserts only mem_rd_o; 1010 asserts reg_wr_o, mem_to_reg_o and pc_en_o with reg_dst_o = 0; mem_to_reg_o is high in no other state.
- R9: 1100 asserts exactly mem_wr_o and pc_en_o; reg_wr_o, mem_wr_o and ir_en_o are never high together.
- R10: Counting from fetch to the next fetch, instructions take branch 3, register-register 4, OR-immediate 4, load 5, store 4 and an unrecognised opcode 2 cycles; every state with pc_en_o high is followed by fetch, and the opcode has no effect outside decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | OPC_W | Opcode field of the latched instruction |
| eq_i | input | 1 | Equality flag captured by the datapath in decode |
| state_o | output | 4 | Current state code |
| ir_en_o | output | 1 | Instruction register load enable |
| a_en_o | output | 1 | First operand register load enable |
| b_en_o | output | 1 | Second operand register load enable |
| e_en_o | output | 1 | Equality register load enable |
| s_en_o | output | 1 | ALU result register load enable |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 OR, 10 function code |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| reg_wr_o | output | 1 | Register file write enable |
| reg_dst_o | output | 1 | Write register select: 1 rd, 0 rt |
| mem_to_reg_o | output | 1 | Write data select: 1 memory, 0 ALU result |
| pc_en_o | output | 1 | PC load enable |
| pc_sel_o | output | 1 | PC source: 1 branch target, 0 PC + 4 |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode with the standard five opcode values and a two-stage reset synchroniser. With six opcode bits the random stimulus reaches every one of the 64 codes in decode, so all 59 unrecognised codes as well as the five legal ones are dispatched, and the opcode is also scrambled in the non-decode states to show it is ignored there. The two-stage synchroniser fixes the release delay at a known three edges, which the bench's reference model tracks both at start-up and after a reset applied in the middle of an instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int ST_W      = 4;
  localparam int ALU_W     = 2;
  localparam int N_CLASSES = 5;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'b0000,
    S_DECODE = 4'b0001,
    S_BR     = 4'b0011,
    S_RR_EX  = 4'b0100,
    S_RR_WB  = 4'b0101,
    S_OI_EX  = 4'b0110,
    S_OI_WB  = 4'b0111,
    S_LD_EX  = 4'b1000,
    S_LD_MEM = 4'b1001,
    S_LD_WB  = 4'b1010,
    S_ST_EX  = 4'b1011,
    S_ST_MEM = 4'b1100
  } state_t;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD  = 2'b00,
    ALU_OR   = 2'b01,
    ALU_FUNC = 2'b10
  } alu_op_t;

  typedef struct packed {
    logic    ir_en;
    logic    a_en;
    logic    b_en;
    logic    e_en;
    logic    s_en;
    alu_op_t alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    reg_wr;
    logic    reg_dst;
    logic    mem_to_reg;
    logic    pc_en;
    logic    pc_br;
  } ctrl_t;

endpackage

// File: rtl/mc_ctrl_rst_sync.sv
module mc_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int             OPC_W     = 6,
  parameter logic [OPC_W-1:0] OPC_BEQ = OPC_W'(6'b000100),
  parameter logic [OPC_W-1:0] OPC_RR  = OPC_W'(6'b000000),
  parameter logic [OPC_W-1:0] OPC_ORI = OPC_W'(6'b001101),
  parameter logic [OPC_W-1:0] OPC_LD  = OPC_W'(6'b100011),
  parameter logic [OPC_W-1:0] OPC_ST  = OPC_W'(6'b101011)
) (
  input  state_t           state_i,
  input  logic [OPC_W-1:0] opcode_i,
  output state_t           state_o
);

  localparam logic [OPC_W-1:0] OPC_TAB [N_CLASSES] =
    '{OPC_BEQ, OPC_RR, OPC_ORI, OPC_LD, OPC_ST};
  localparam state_t ENTRY_TAB [N_CLASSES] =
    '{S_BR, S_RR_EX, S_OI_EX, S_LD_EX, S_ST_EX};

  state_t dispatch;

  // lowest table index wins if two opcode parameters are set equal
  always_comb begin
    dispatch = S_FETCH;
    for (int k = N_CLASSES - 1; k >= 0; k--) begin
      if (opcode_i == OPC_TAB[k]) dispatch = ENTRY_TAB[k];
    end
  end

  always_comb begin
    unique case (state_i)
      S_FETCH:  state_o = S_DECODE;
      S_DECODE: state_o = dispatch;
      S_RR_EX:  state_o = S_RR_WB;
      S_OI_EX:  state_o = S_OI_WB;
      S_LD_EX:  state_o = S_LD_MEM;
      S_LD_MEM: state_o = S_LD_WB;
      S_ST_EX:  state_o = S_ST_MEM;
      default:  state_o = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_outdec.sv
module mc_ctrl_outdec
  import mc_ctrl_pkg::*;
(
  input  state_t state_i,
  input  logic   eq_i,
  output ctrl_t  ctrl_o,
  output logic   pc_sel_o
);

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (state_i)
      S_FETCH: begin
        ctrl_o.ir_en  = 1'b1;
        ctrl_o.mem_rd = 1'b1;
      end
      S_DECODE: begin
        ctrl_o.a_en = 1'b1;
        ctrl_o.b_en = 1'b1;
        ctrl_o.e_en = 1'b1;
      end
      S_BR: begin
        ctrl_o.pc_en = 1'b1;
        ctrl_o.pc_br = 1'b1;
      end
      S_RR_EX: begin
        ctrl_o.s_en   = 1'b1;
        ctrl_o.alu_op = ALU_FUNC;
      end
      S_OI_EX: begin
        ctrl_o.s_en   = 1'b1;
        ctrl_o.alu_op = ALU_OR;
      end
      S_LD_EX, S_ST_EX: begin
        ctrl_o.s_en   = 1'b1;
        ctrl_o.alu_op = ALU_ADD;
      end
      S_RR_WB: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = 1'b1;
        ctrl_o.pc_en   = 1'b1;
      end
      S_OI_WB: begin
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.pc_en  = 1'b1;
      end
      S_LD_MEM: begin
        ctrl_o.mem_rd = 1'b1;
      end
      S_LD_WB: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.pc_en      = 1'b1;
      end
      S_ST_MEM: begin
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.pc_en  = 1'b1;
      end
      default: ;
    endcase
  end

  // only the branch state lets the equality flag pick the target
  assign pc_sel_o = ctrl_o.pc_br & eq_i;

  always_comb begin
    if (ctrl_o.mem_to_reg) begin
      a_m2r_wb_r8 : assert (ctrl_o.reg_wr && !ctrl_o.reg_dst);
    end
  end

endmodule

// File: rtl/mc_ctrl_streg.sv
module mc_ctrl_streg
  import mc_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_t state_d_i,
  output state_t state_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q_o <= S_FETCH;
    else         state_q_o <= state_d_i;
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int               OPC_W       = 6,
  parameter logic [OPC_W-1:0] OPC_BEQ     = OPC_W'(6'b000100),
  parameter logic [OPC_W-1:0] OPC_RR      = OPC_W'(6'b000000),
  parameter logic [OPC_W-1:0] OPC_ORI     = OPC_W'(6'b001101),
  parameter logic [OPC_W-1:0] OPC_LD      = OPC_W'(6'b100011),
  parameter logic [OPC_W-1:0] OPC_ST      = OPC_W'(6'b101011),
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             eq_i,
  output logic [ST_W-1:0]  state_o,
  output logic             ir_en_o,
  output logic             a_en_o,
  output logic             b_en_o,
  output logic             e_en_o,
  output logic             s_en_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             reg_wr_o,
  output logic             reg_dst_o,
  output logic             mem_to_reg_o,
  output logic             pc_en_o,
  output logic             pc_sel_o
);

  logic   rst_int_n;
  state_t state_q;
  state_t state_d;
  ctrl_t  ctrl;

  mc_ctrl_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  mc_ctrl_next #(
    .OPC_W   (OPC_W),
    .OPC_BEQ (OPC_BEQ),
    .OPC_RR  (OPC_RR),
    .OPC_ORI (OPC_ORI),
    .OPC_LD  (OPC_LD),
    .OPC_ST  (OPC_ST)
  ) i_next (
    .state_i  (state_q),
    .opcode_i (opcode_i),
    .state_o  (state_d)
  );

  mc_ctrl_streg i_streg (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .state_d_i (state_d),
    .state_q_o (state_q)
  );

  mc_ctrl_outdec i_outdec (
    .state_i  (state_q),
    .eq_i     (eq_i),
    .ctrl_o   (ctrl),
    .pc_sel_o (pc_sel_o)
  );

  assign state_o      = state_q;
  assign ir_en_o      = ctrl.ir_en;
  assign a_en_o       = ctrl.a_en;
  assign b_en_o       = ctrl.b_en;
  assign e_en_o       = ctrl.e_en;
  assign s_en_o       = ctrl.s_en;
  assign alu_op_o     = ctrl.alu_op;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign reg_wr_o     = ctrl.reg_wr;
  assign reg_dst_o    = ctrl.reg_dst;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign pc_en_o      = ctrl.pc_en;

  logic opc_known;
  assign opc_known = (opcode_i == OPC_BEQ) || (opcode_i == OPC_RR) ||
                     (opcode_i == OPC_ORI) || (opcode_i == OPC_LD) ||
                     (opcode_i == OPC_ST);

  p_fetch_to_decode_r2 : assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_q == S_FETCH) |=> (state_q == S_DECODE));

  p_bad_opcode_r4 : assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_q == S_DECODE && !opc_known) |=> (state_q == S_FETCH));

  p_pc_then_fetch_r10 : assert property (@(posedge clk_i) disable iff (!rst_int_n)
    pc_en_o |=> (state_q == S_FETCH));

  p_pc_sel_r5 : assert property (@(posedge clk_i) disable iff (!rst_int_n)
    pc_sel_o |-> (pc_en_o && eq_i && state_q == S_BR));

  p_write_excl_r9 : assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $onehot0({reg_wr_o, mem_wr_o, ir_en_o}));

  p_load_chain_r7 : assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_q == S_LD_MEM) |-> ($past(state_q) == S_LD_EX));

endmodule

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;

  localparam int OPC_W = 6;
  localparam int SYNC  = 2;

  logic             clk;
  logic             rst_n;
  logic [OPC_W-1:0] opc;
  logic             eq;
  logic [3:0]       st;
  logic             ir_en, a_en, b_en, e_en, s_en;
  logic [1:0]       alu_op;
  logic             mem_rd, mem_wr, reg_wr, reg_dst, m2r, pc_en, pc_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .opcode_i     (opc),
    .eq_i         (eq),
    .state_o      (st),
    .ir_en_o      (ir_en),
    .a_en_o       (a_en),
    .b_en_o       (b_en),
    .e_en_o       (e_en),
    .s_en_o       (s_en),
    .alu_op_o     (alu_op),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .reg_wr_o     (reg_wr),
    .reg_dst_o    (reg_dst),
    .mem_to_reg_o (m2r),
    .pc_en_o      (pc_en),
    .pc_sel_o     (pc_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference encodings from the requirements
  localparam logic [5:0] O_BEQ = 6'b000100, O_RR = 6'b000000, O_ORI = 6'b001101,
                         O_LD  = 6'b100011, O_ST = 6'b101011;

  function automatic logic [3:0] ref_next(logic [3:0] s, logic [5:0] o);
    case (s)
      4'b0000: return 4'b0001;
      4'b0001: begin
        if (o == O_BEQ) return 4'b0011;                 // R3
        if (o == O_RR)  return 4'b0100;
        if (o == O_ORI) return 4'b0110;
        if (o == O_LD)  return 4'b1000;
        if (o == O_ST)  return 4'b1011;
        return 4'b0000;                                 // R4
      end
      4'b0100: return 4'b0101;
      4'b0110: return 4'b0111;
      4'b1000: return 4'b1001;
      4'b1001: return 4'b1010;
      4'b1011: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  // {ir,a,b,e,s,alu[1:0],mrd,mwr,rwr,dst,m2r,pcen,pcsel}
  function automatic logic [14:0] ref_ctl(logic [3:0] s, logic e);
    case (s)
      4'b0000: return 15'b1_0_0_0_0_00_1_0_0_0_0_0_0;
      4'b0001: return 15'b0_1_1_1_0_00_0_0_0_0_0_0_0;
      4'b0011: return {13'b0_0_0_0_0_00_0_0_0_0_0_1, 1'b0, e} >> 1 | {14'b0, e} | 15'b10;
      4'b0100: return 15'b0_0_0_0_1_10_0_0_0_0_0_0_0;
      4'b0101: return 15'b0_0_0_0_0_00_0_0_1_1_0_1_0;
      4'b0110: return 15'b0_0_0_0_1_01_0_0_0_0_0_0_0;
      4'b0111: return 15'b0_0_0_0_0_00_0_0_1_0_0_1_0;
      4'b1000: return 15'b0_0_0_0_1_00_0_0_0_0_0_0_0;
      4'b1001: return 15'b0_0_0_0_0_00_1_0_0_0_0_0_0;
      4'b1010: return 15'b0_0_0_0_0_00_0_0_1_0_1_1_0;
      4'b1011: return 15'b0_0_0_0_1_00_0_0_0_0_0_0_0;
      4'b1100: return 15'b0_0_0_0_0_00_0_1_0_0_0_1_0;
      default: return 15'b0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] s);
    case (s)
      4'b0000: return "R1/R2";
      4'b0001: return "R2";
      4'b0011: return "R5";
      4'b0100, 4'b0110: return "R6";
      4'b1000, 4'b1011: return "R6";
      4'b0101, 4'b0111: return "R7";
      4'b1001, 4'b1010: return "R8";
      4'b1100: return "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic int ref_len(logic [5:0] o);
    if (o == O_BEQ) return 3;
    if (o == O_RR || o == O_ORI || o == O_ST) return 4;
    if (o == O_LD) return 5;
    return 2;
  endfunction

  logic [3:0] m_state;
  int         hold;
  int         cyc;
  int         exp_len;
  bit         pending;

  task automatic check_cycle();
    logic [14:0] got, exp;
    got = {ir_en, a_en, b_en, e_en, s_en, alu_op, mem_rd, mem_wr, reg_wr,
           reg_dst, m2r, pc_en, pc_sel};
    exp = ref_ctl(m_state, eq);
    checks++;
    if (st !== m_state) begin
      errors++;
      $display("FAIL R3 state code: actual=%b expected=%b", st, m_state);
    end
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s controls in state %b: actual=%b expected=%b",
               req_of(m_state), m_state, got, exp);
    end
    // R10 fetch-to-fetch latency measured at the ports
    if (ir_en === 1'b1) begin
      if (pending) begin
        checks++;
        if (cyc != exp_len) begin
          errors++;
          $display("FAIL R10 latency: actual=%0d expected=%0d", cyc, exp_len);
        end
        pending = 0;
      end
      cyc = 0;
    end
    cyc++;
  endtask

  // drive one cycle: called at negedge after checking
  task automatic step(input logic [5:0] o, input logic e);
    opc = o;
    eq  = e;
    if (m_state == 4'b0001 && hold == 0) begin
      exp_len = ref_len(o);
      pending = 1;
    end
    @(posedge clk);
    if (hold > 0) hold--;
    else          m_state = ref_next(m_state, o);
    @(negedge clk);
    check_cycle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    m_state = 4'b0000;
    pending = 0;
    cyc     = 0;
    checks++;   // R1 asynchronous entry into fetch
    if (st !== 4'b0000 || ir_en !== 1'b1 || mem_rd !== 1'b1 || reg_wr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: actual=%b expected=0000", st);
    end
    repeat (3) @(negedge clk);
    check_cycle();
    rst_n = 1'b1;
    hold  = SYNC;
  endtask

  logic [5:0] legal [5] = '{O_BEQ, O_RR, O_ORI, O_LD, O_ST};

  initial begin
    opc   = '0;
    eq    = 1'b0;
    rst_n = 1'b0;
    m_state = 4'b0000;
    hold = 0; cyc = 0; exp_len = 0; pending = 0;
    void'($urandom(32'd20240601));
    @(negedge clk);
    do_reset();
    // R1: three edges after release before decode
    for (int i = 0; i < 3; i++) step(O_RR, 1'b0);
    // directed: each kind with both flag values, plus two unknown codes (R3 R4 R5)
    for (int k = 0; k < 5; k++) begin
      for (int e = 0; e < 2; e++) begin
        while (m_state != 4'b0001) step(6'h3F, e[0]);
        step(legal[k], e[0]);
        while (m_state != 4'b0000) step(~legal[k], e[0]);  // R10 opcode ignored
      end
    end
    while (m_state != 4'b0001) step(6'b111111, 1'b1);
    step(6'b111111, 1'b1);                                 // R4
    while (m_state != 4'b0001) step(6'b000001, 1'b0);
    step(6'b000001, 1'b0);                                 // R4
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] o;
      if ($urandom_range(0, 9) < 7) o = legal[$urandom_range(0, 4)];
      else                          o = 6'($urandom);
      step(o, 1'($urandom));
      if (i == 2000) begin
        while (m_state != 4'b1001) begin
          if (m_state == 4'b0001) step(O_LD, 1'b0);
          else                    step(6'($urandom), 1'b0);
        end
        do_reset();                                        // R1 mid-load
        for (int j = 0; j < 3; j++) step(O_LD, 1'b0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule